// File: doc/BRIEF.md
# Lowest Bit Manipulation Unit

This unit takes one scalar data word and a 4-bit operation code and returns a result word together with a zero flag and a carry flag. Each operation acts on the word around its lowest set bit or its lowest clear bit. The operations isolate that bit, clear it, set it, build masks that end at it, or fill the bits below it. A further operation counts trailing zeros. All of them are built from the word's increment, decrement, negation and complement, so one shared adder layer serves every opcode.

The unit sits in the execute stage of a general-purpose integer datapath, beside the shifter and the adder. The word width is a parameter. A parameter also chooses whether the outputs leave through a register stage, giving one cycle of latency, or straight from the logic with no latency. When the register stage is present, it loads only in cycles where the input is marked valid, and it holds its contents otherwise.

Top module: `lowbit_unit`

## Requirements
- R1: Opcode 0x0 returns only the lowest set bit of the source, with every other bit cleared; a zero source gives zero.
- R2: Opcode 0x1 returns ones from bit 0 up to and including the lowest set bit; a zero source gives all ones.
- R3: Opcode 0x2 returns the source with its lowest set bit cleared and all other bits unchanged.
- R4: Opcode 0x3 returns the number of trailing zero bits, zero-extended. A zero source returns the word width and raises the carry flag. The carry flag is 0 for every other source and for every other opcode.
- R5: Opcode 0x4 returns only the lowest clear bit, set to one (zero if the source is all ones). Opcode 0x5 returns all ones except a zero at the lowest clear bit position.
- R6: Opcode 0x6 returns the source with its lowest clear bit set. Opcode 0x7 returns ones from bit 0 up to and including the lowest clear bit (all ones if the source is all ones).
- R7: Opcode 0x8 returns the source with every bit below its lowest clear bit cleared, so an all-ones source gives zero.
- R8: Opcode 0x9 returns the source with every bit below its lowest set bit set, so a zero source gives all ones. Opcode 0xA returns all ones except a zero at the lowest set bit position.
- R9: Opcode 0xB returns zeros at the trailing-ones positions and ones elsewhere. Opcode 0xC returns ones exactly at the trailing-zeros positions.
- R10: Opcodes 0xD, 0xE and 0xF return a zero result, with the zero flag at 1 and the carry flag at 0.
- R11: The zero flag is 1 exactly when the result word is all zeros, for every opcode.
- R12: With the register stage enabled (the default), the result and its valid appear one clock after a valid input. Cycles without a valid input drop the output valid and leave the result and flags unchanged.
- R13: While reset is asserted, the output valid, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Source and opcode are valid this cycle |
| in_op | input | 4 | Operation code |
| in_src | input | WIDTH | Source word |
| out_vld | output | 1 | Result is valid |
| out_res | output | WIDTH | Result word |
| out_zf | output | 1 | Result is all zeros |
| out_cf | output | 1 | Trailing-zero count of a zero source |

## Verification
Some properties are checked on every cycle. The zero flag must agree with the result. A raised carry flag must come with a result equal to the width. An isolate-lowest-set result must have at most one bit set. Clearing the lowest set bit must remove exactly one bit, and setting the lowest clear bit must add exactly one. Invalid opcodes must give zero. The output valid must follow the input valid one cycle later.

Only the bench scenarios show that each opcode gives the exact bit pattern for a given source. They do this with a model built from bit-position scans, driven by zero, all-ones, every single-bit word and random words. The same scenarios show that the output holds during idle cycles.

// File: rtl/lowbit_pkg.sv
package lowbit_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ISO_SET   = 4'h0,
    OP_MSK_SET   = 4'h1,
    OP_CLR_SET   = 4'h2,
    OP_TZ_COUNT  = 4'h3,
    OP_ISO_CLR   = 4'h4,
    OP_ISO_CLR_N = 4'h5,
    OP_SET_CLR   = 4'h6,
    OP_MSK_CLR   = 4'h7,
    OP_FILL_CLR  = 4'h8,
    OP_FILL_SET  = 4'h9,
    OP_ISO_SET_N = 4'hA,
    OP_INV_ONES  = 4'hB,
    OP_MSK_ZEROS = 4'hC
  } lowbit_op_e;

  localparam logic [OP_W-1:0] OP_LAST_VALID = 4'hC;
endpackage

// File: rtl/lowbit_arith.sv
// Shared neighbour values of the source word: every operation is a
// bitwise combination of these four.
module lowbit_arith #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dec,
  output logic [WIDTH-1:0] inc,
  output logic [WIDTH-1:0] neg,
  output logic [WIDTH-1:0] inv
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    inv = ~src;
    dec = src - ONE;
    inc = src + ONE;
    neg = inv + ONE;
  end
endmodule

// File: rtl/lowbit_tzcount.sv
// Trailing-zero count: encodes the position of the isolated lowest set
// bit with one OR tree per count bit; a zero source yields WIDTH.
module lowbit_tzcount #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] iso,
  input  logic             src_zero,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0][WIDTH-1:0] terms;
  logic [CNT_W-1:0]            enc;

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      if (((i >> b) % 2) == 1) begin : g_use
        assign terms[b][i] = iso[i];
      end else begin : g_skip
        assign terms[b][i] = 1'b0;
      end
    end
    assign enc[b] = |terms[b];
  end

  always_comb begin
    if (src_zero) count = CNT_W'(WIDTH);
    else          count = enc;
  end
endmodule

// File: rtl/lowbit_select.sv
// Opcode decode and result selection, plus the two status flags.
module lowbit_select
  import lowbit_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dec,
  input  logic [WIDTH-1:0] inc,
  input  logic [WIDTH-1:0] neg,
  input  logic [WIDTH-1:0] inv,
  input  logic [CNT_W-1:0] tz,
  input  logic             src_zero,
  output logic [WIDTH-1:0] res,
  output logic             zf,
  output logic             cf
);
  lowbit_op_e opc;

  always_comb begin
    opc = lowbit_op_e'(op);
    cf  = 1'b0;
    case (opc)
      OP_ISO_SET:   res = src & neg;
      OP_MSK_SET:   res = src ^ dec;
      OP_CLR_SET:   res = src & dec;
      OP_TZ_COUNT: begin
        res = {{(WIDTH-CNT_W){1'b0}}, tz};
        cf  = src_zero;
      end
      OP_ISO_CLR:   res = inv & inc;
      OP_ISO_CLR_N: res = src | ~inc;
      OP_SET_CLR:   res = src | inc;
      OP_MSK_CLR:   res = src ^ inc;
      OP_FILL_CLR:  res = src & inc;
      OP_FILL_SET:  res = src | dec;
      OP_ISO_SET_N: res = inv | dec;
      OP_INV_ONES:  res = inv | inc;
      OP_MSK_ZEROS: res = inv & dec;
      default:      res = '0;
    endcase
    zf = (res == '0);
  end
endmodule

// File: rtl/lowbit_outstage.sv
// Output timing variant: a clock-enabled register stage or a pass-through.
module lowbit_outstage #(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_vld,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_zf,
  input  logic             d_cf,
  output logic             q_vld,
  output logic [WIDTH-1:0] q_res,
  output logic             q_zf,
  output logic             q_cf
);
  if (OUT_REG) begin : g_reg
    logic             vld_r, vld_nxt;
    logic [WIDTH-1:0] res_r, res_nxt;
    logic             zf_r, zf_nxt;
    logic             cf_r, cf_nxt;
    logic             load_en;

    always_comb begin
      load_en = d_vld;
      vld_nxt = d_vld;
      res_nxt = load_en ? d_res : res_r;
      zf_nxt  = load_en ? d_zf  : zf_r;
      cf_nxt  = load_en ? d_cf  : cf_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        res_r <= '0;
        zf_r  <= 1'b0;
        cf_r  <= 1'b0;
      end else begin
        vld_r <= vld_nxt;
        res_r <= res_nxt;
        zf_r  <= zf_nxt;
        cf_r  <= cf_nxt;
      end
    end

    assign q_vld = vld_r;
    assign q_res = res_r;
    assign q_zf  = zf_r;
    assign q_cf  = cf_r;
  end else begin : g_comb
    assign q_vld = d_vld;
    assign q_res = d_res;
    assign q_zf  = d_zf;
    assign q_cf  = d_cf;
  end
endmodule

// File: rtl/lowbit_unit.sv
module lowbit_unit
  import lowbit_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_src,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_res,
  output logic             out_zf,
  output logic             out_cf
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] dec, inc, neg, inv, iso;
  logic [CNT_W-1:0] tz;
  logic             src_zero;
  logic [WIDTH-1:0] res_c;
  logic             zf_c, cf_c;

  assign src_zero = (in_src == '0);
  assign iso      = in_src & neg;

  lowbit_arith #(.WIDTH(WIDTH)) u_arith (
    .src (in_src),
    .dec (dec),
    .inc (inc),
    .neg (neg),
    .inv (inv)
  );

  lowbit_tzcount #(.WIDTH(WIDTH)) u_tz (
    .iso      (iso),
    .src_zero (src_zero),
    .count    (tz)
  );

  lowbit_select #(.WIDTH(WIDTH)) u_sel (
    .op       (in_op),
    .src      (in_src),
    .dec      (dec),
    .inc      (inc),
    .neg      (neg),
    .inv      (inv),
    .tz       (tz),
    .src_zero (src_zero),
    .res      (res_c),
    .zf       (zf_c),
    .cf       (cf_c)
  );

  lowbit_outstage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_vld (in_vld),
    .d_res (res_c),
    .d_zf  (zf_c),
    .d_cf  (cf_c),
    .q_vld (out_vld),
    .q_res (out_res),
    .q_zf  (out_zf),
    .q_cf  (out_cf)
  );
endmodule

// File: rtl/lowbit_unit_chk.sv
module lowbit_unit_chk #(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [3:0]       in_op,
  input logic [WIDTH-1:0] in_src,
  input logic             out_vld,
  input logic [WIDTH-1:0] out_res,
  input logic             out_zf,
  input logic             out_cf
);
  logic [3:0]       c_op;
  logic [WIDTH-1:0] c_src;
  logic             c_vld;

  if (OUT_REG) begin : g_track
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_op  <= '0;
        c_src <= '0;
        c_vld <= 1'b0;
      end else begin
        c_vld <= in_vld;
        if (in_vld) begin
          c_op  <= in_op;
          c_src <= in_src;
        end
      end
    end
  end else begin : g_pass
    assign c_op  = in_op;
    assign c_src = in_src;
    assign c_vld = in_vld;
  end

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_zf == (out_res == '0)));

  // R4
  carry_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_cf) |-> (out_res == WIDTH) && (c_op == 4'h3));

  // R1
  iso_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && c_op == 4'h0) |-> $onehot0(out_res));

  // R3
  clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && c_op == 4'h2 && c_src != '0)
      |-> ($countones(out_res) == $countones(c_src) - 1));

  // R6
  set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && c_op == 4'h6 && c_src != '1)
      |-> ($countones(out_res) == $countones(c_src) + 1));

  // R10
  invalid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && c_op > 4'hC) |-> (out_res == '0 && out_zf && !out_cf));

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == c_vld);
endmodule

bind lowbit_unit lowbit_unit_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_op   (in_op),
  .in_src  (in_src),
  .out_vld (out_vld),
  .out_res (out_res),
  .out_zf  (out_zf),
  .out_cf  (out_cf)
);

// File: tb/tb_lowbit_unit.sv
module tb_lowbit_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] src;
    logic [W-1:0] res;
    logic         zf;
    logic         cf;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic [3:0]   in_op;
  logic [W-1:0] in_src;
  logic         out_vld;
  logic [W-1:0] out_res;
  logic         out_zf, out_cf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [W-1:0] last_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowbit_unit #(.WIDTH(W), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_src(in_src), .out_vld(out_vld), .out_res(out_res),
    .out_zf(out_zf), .out_cf(out_cf)
  );

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R4";
      4'h4, 4'h5: return "R5";
      4'h6, 4'h7: return "R6";
      4'h8: return "R7";
      4'h9, 4'hA: return "R8";
      4'hB, 4'hC: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Model from bit-position scans.
  function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] x);
    exp_t e;
    int ls = W;
    int lc = W;
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i])  ls = i;
      if (!x[i]) lc = i;
    end
    e.cf = 1'b0;
    case (op)
      4'h0: if (ls < W) r[ls] = 1'b1;
      4'h1: for (int i = 0; i < W; i++) r[i] = (i <= ls);
      4'h2: begin r = x; if (ls < W) r[ls] = 1'b0; end
      4'h3: begin r = W'(ls); e.cf = (ls == W); end
      4'h4: if (lc < W) r[lc] = 1'b1;
      4'h5: begin r = '1; if (lc < W) r[lc] = 1'b0; end
      4'h6: begin r = x; if (lc < W) r[lc] = 1'b1; end
      4'h7: for (int i = 0; i < W; i++) r[i] = (i <= lc);
      4'h8: begin r = x; for (int i = 0; i < W; i++) if (i < lc) r[i] = 1'b0; end
      4'h9: begin r = x; for (int i = 0; i < W; i++) if (i < ls) r[i] = 1'b1; end
      4'hA: begin r = '1; if (ls < W) r[ls] = 1'b0; end
      4'hB: for (int i = 0; i < W; i++) r[i] = (i >= lc);
      4'hC: for (int i = 0; i < W; i++) r[i] = (i < ls);
      default: r = '0;
    endcase
    e.op = op; e.src = x; e.res = r; e.zf = (r == '0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [W-1:0] x);
    @(negedge clk);
    #1;
    in_vld = 1'b1; in_op = op; in_src = x;
    sb.push_back(model(op, x));
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    in_vld = 1'b0; in_op = 4'h0; in_src = '0;
  endtask

  // Monitor: outputs change at posedge, sampled at negedge.
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected output res=%h expected none", out_res);
      end else begin
        e = sb.pop_front();
        if (out_res !== e.res || out_zf !== e.zf || out_cf !== e.cf) begin
          errors++;
          $display("FAIL %s/R11 op=%h src=%h res=%h zf=%b cf=%b expected res=%h zf=%b cf=%b",
                   tag(e.op), e.op, e.src, out_res, out_zf, out_cf, e.res, e.zf, e.cf);
        end
        last_res = e.res;
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state
    checks++;
    if (out_vld !== 1'b0 || out_res !== '0 || out_zf !== 1'b0 || out_cf !== 1'b0) begin
      errors++;
      $display("FAIL R13 vld=%b res=%h zf=%b cf=%b expected all 0",
               out_vld, out_res, out_zf, out_cf);
    end
    rst_n = 1'b1;

    // Corner words for every opcode, valid and invalid (R1..R11)
    for (int op = 0; op < 16; op++) begin
      drive(4'(op), '0);
      drive(4'(op), '1);
      drive(4'(op), 32'hA5A5_0F00);
      for (int b = 0; b < W; b++) begin
        drive(4'(op), W'(1) << b);
        drive(4'(op), ~(W'(1) << b));
      end
    end
    // Random words, with idle gaps to exercise the hold path (R12)
    for (int n = 0; n < 400; n++) begin
      drive(4'($urandom_range(0, 15)), W'($urandom));
      if (n % 7 == 0) idle();
    end
    drive(4'h3, 32'h0000_0100);
    idle();
    repeat (2) @(negedge clk);
    // R12: idle cycles drop valid and hold the last result
    checks++;
    if (out_vld !== 1'b0 || out_res !== last_res || sb.size() != 0) begin
      errors++;
      $display("FAIL R12 vld=%b res=%h pending=%0d expected vld=0 res=%h pending=0",
               out_vld, out_res, sb.size(), last_res);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule